// File: doc/BRIEF.md
# Warp Branch Divergence and Reconvergence Controller

This unit steers control flow for one warp of 32 lanes that share a single program counter. It keeps the warp's program counter and a 32-bit enable vector, where bit j belongs to lane j. When the issue stage reports a conditional branch together with a per-lane outcome vector, the unit works out whether the enabled lanes agree. If they agree, the whole warp jumps or falls through. If they disagree, the two groups run one after the other: the taken group first, with only its lanes enabled, and then the not-taken group. The full incoming enable vector returns once the warp reaches the branch's reconvergence address.

Divergence state is kept on a small last-in, first-out store. Each diverging branch pushes two records: a restore record (reconvergence address, full mask) and a pending-path record (fall-through address, not-taken mask). When the next program counter equals the reconvergence address of the newest record, that record is removed and its address and mask take over. Branches can therefore nest until the store is full. A split that finds too little room raises a sticky error and changes nothing else.

Top module: `simt_warp_divergence`

## Requirements
- R1: During and directly after a synchronous active-low reset, `pc` is 0, `act_mask` is 0 and `ovf_err` is 0.
- R2: A `launch` loads `pc` from `launch_pc` and `act_mask` from `launch_mask`, empties the divergence store and clears `ovf_err`. It takes priority over `br` and `adv`.
- R3: With `adv` high and `br` low, the next `pc` is `pc + 1`. With neither high, `pc` and `act_mask` hold.
- R4: On `br`, if `br_taken & act_mask` equals `act_mask`, the next `pc` is `br_target`, the mask is kept and nothing is stored. Bit j of every mask and of `br_taken` belongs to lane j.
- R5: On `br`, if `br_taken & act_mask` is zero, the next `pc` is `br_fallthru` and the mask is kept. `br_taken` bits outside the mask have no effect.
- R6: On `br` with any other outcome (a split), the next `pc` is `br_target`, the next mask is `br_taken & act_mask`, and two records are stored.
- R7: When a step (`adv` or a non-splitting `br`) would move `pc` onto the reconvergence address of the newest record, that record is removed. For the first such arrival `pc` becomes `br_fallthru` and the mask becomes the old mask with the taken lanes cleared.
- R8: On the second arrival, the restore record is removed, `pc` equals the reconvergence address and the full pre-branch mask is restored.
- R9: Nested splits resolve last-in, first-out, so inner paths reconverge before outer ones.
- R10: A split with fewer than two free records (store of `DEPTH` records) sets `ovf_err`, leaves `pc` and `act_mask` unchanged, and `ovf_err` stays set until the next `launch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| launch | input | 1 | Start the warp at a new address with a new mask |
| launch_pc | input | PC_W | Start address |
| launch_mask | input | LANES | Start enable vector |
| adv | input | 1 | Sequential step: the warp moves to the next address |
| br | input | 1 | Conditional branch issued this cycle |
| br_taken | input | LANES | Per-lane branch outcome, bit j for lane j |
| br_target | input | PC_W | Taken-path address |
| br_reconv | input | PC_W | Address where both paths join again |
| br_fallthru | input | PC_W | Not-taken-path address |
| pc | output | PC_W | Current warp program counter |
| act_mask | output | LANES | Current lane enable vector |
| ovf_err | output | 1 | Sticky divergence-store overflow flag |

## Verification
The assertions assume a well-formed instruction stream. The branch target and fall-through address both differ from the reconvergence address, so each side holds at least one instruction, and a taken path that nests stays inside its parent region. Directed sequences are built to meet this: sequential steps walk each path up to its join address. A randomised phase draws addresses from a narrow window, so that joins actually occur. In that phase the bench's behavioural model follows the same stated rules even when the stream is malformed, so every cycle's comparison stays valid.

// File: rtl/simt_pkg.sv
// Package: shared types for the warp divergence controller.
// Assumes: nothing; holds only the branch outcome classification.
package simt_pkg;

    // Outcome of the branch input in one cycle, judged against the live mask.
    typedef enum logic [1:0] {
        BK_IDLE       = 2'd0,
        BK_ALL_TAKEN  = 2'd1,
        BK_NONE_TAKEN = 2'd2,
        BK_SPLIT      = 2'd3
    } branch_kind_e;

endpackage

// File: rtl/simt_branch_classify.sv
// Module: simt_branch_classify
// Sorts a branch into all-taken, none-taken or split with respect to the
// currently enabled lanes, and forms the two lane groups.
// Assumes: lane j of every vector is bit j; purely combinational.
module simt_branch_classify
    import simt_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic             br,
    input  logic [LANES-1:0] taken,
    input  logic [LANES-1:0] live_mask,
    output branch_kind_e     kind,
    output logic [LANES-1:0] taken_grp,
    output logic [LANES-1:0] other_grp
);

    // Lane groups: lanes outside the live mask belong to neither side.
    always_comb begin
        taken_grp = taken & live_mask;
        other_grp = live_mask & ~taken;
    end

    // Classify the outcome.
    always_comb begin
        if (!br)
            kind = BK_IDLE;
        else if (taken_grp == live_mask)
            kind = BK_ALL_TAKEN;
        else if (taken_grp == '0)
            kind = BK_NONE_TAKEN;
        else
            kind = BK_SPLIT;
    end

endmodule

// File: rtl/simt_recon_stack.sv
// Module: simt_recon_stack
// Last-in, first-out store of divergence records {join address, resume
// address, mask}. A push writes a pair of records in one cycle; a pop removes
// one. Flush empties it.
// Assumes: DEPTH >= 2; the caller never pushes without room2 and never pops
// while empty; push and pop are not raised together.
module simt_recon_stack #(
    parameter int LANES = 32,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_pair,
    input  logic [PC_W-1:0]  join_pc,
    input  logic [PC_W-1:0]  alt_pc,
    input  logic [LANES-1:0] full_mask,
    input  logic [LANES-1:0] alt_mask,
    input  logic             pop,
    output logic [PC_W-1:0]  top_join,
    output logic [PC_W-1:0]  top_resume,
    output logic [LANES-1:0] top_mask,
    output logic             nonempty,
    output logic             room2
);

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PC_W-1:0]  join_pc;
        logic [PC_W-1:0]  resume_pc;
        logic [LANES-1:0] mask;
    } rec_t;

    rec_t            recs [DEPTH];
    logic [CW-1:0]   count;
    logic [CW-1:0]   top_idx;

    // Occupancy counter: flush empties, a push adds two, a pop removes one.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            count <= '0;
        else if (push_pair)
            count <= count + CW'(2);
        else if (pop)
            count <= count - CW'(1);
    end

    // One register per record; the lower of a pushed pair restores, the upper resumes.
    for (genvar i = 0; i < DEPTH; i++) begin : g_rec
        always_ff @(posedge clk) begin
            if (!rst_n)
                recs[i] <= '0;
            else if (push_pair && !flush && count == CW'(i))
                recs[i] <= '{join_pc: join_pc, resume_pc: join_pc, mask: full_mask};
            else if (push_pair && !flush && count + CW'(1) == CW'(i))
                recs[i] <= '{join_pc: join_pc, resume_pc: alt_pc, mask: alt_mask};
        end
    end

    // Select the newest record.
    always_comb begin
        top_idx    = (count == '0) ? '0 : count - CW'(1);
        top_join   = '0;
        top_resume = '0;
        top_mask   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (top_idx == CW'(i)) begin
                top_join   = recs[i].join_pc;
                top_resume = recs[i].resume_pc;
                top_mask   = recs[i].mask;
            end
        end
    end

    // Status toward the controller.
    always_comb begin
        nonempty = (count != '0);
        room2    = (int'(count) + 2 <= DEPTH);
    end

    assert_push_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_pair && !flush) |-> (int'(count) <= DEPTH - 2));
    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && !push_pair) |-> (count != '0));
    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);
    assert_push_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_pair && !flush) |=> (count == $past(count) + CW'(2)));

endmodule

// File: rtl/simt_warp_divergence.sv
// Module: simt_warp_divergence (top)
// Keeps the shared program counter and the lane enable vector of one warp.
// Serialises divergent branch paths and restores the mask at the join address.
// Assumes: branch target and fall-through differ from the join address;
// br has priority over adv; launch has priority over both.
module simt_warp_divergence
    import simt_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [PC_W-1:0]  launch_pc,
    input  logic [LANES-1:0] launch_mask,
    input  logic             adv,
    input  logic             br,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic [PC_W-1:0]  br_fallthru,
    output logic [PC_W-1:0]  pc,
    output logic [LANES-1:0] act_mask,
    output logic             ovf_err
);

    branch_kind_e     kind;
    logic [LANES-1:0] taken_grp;
    logic [LANES-1:0] other_grp;
    logic [PC_W-1:0]  top_join;
    logic [PC_W-1:0]  top_resume;
    logic [LANES-1:0] top_mask;
    logic             nonempty;
    logic             room2;
    logic [PC_W-1:0]  pc_step;
    logic             do_push;
    logic             do_pop;
    logic             do_ovf;

    simt_branch_classify #(.LANES(LANES)) u_classify (
        .br        (br),
        .taken     (br_taken),
        .live_mask (act_mask),
        .kind      (kind),
        .taken_grp (taken_grp),
        .other_grp (other_grp)
    );

    simt_recon_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (launch),
        .push_pair  (do_push),
        .join_pc    (br_reconv),
        .alt_pc     (br_fallthru),
        .full_mask  (act_mask),
        .alt_mask   (other_grp),
        .pop        (do_pop),
        .top_join   (top_join),
        .top_resume (top_resume),
        .top_mask   (top_mask),
        .nonempty   (nonempty),
        .room2      (room2)
    );

    // Address the warp would move to this cycle, before any join is applied.
    always_comb begin
        unique case (kind)
            BK_ALL_TAKEN, BK_SPLIT: pc_step = br_target;
            BK_NONE_TAKEN:          pc_step = br_fallthru;
            default:                pc_step = adv ? pc + PC_W'(1) : pc;
        endcase
    end

    // Store control: push on a split with room, overflow without, pop on arrival at the join.
    always_comb begin
        do_push = !launch && (kind == BK_SPLIT) && room2;
        do_ovf  = !launch && (kind == BK_SPLIT) && !room2;
        do_pop  = !launch && (kind != BK_SPLIT) && (br || adv) &&
                  nonempty && (pc_step == top_join);
    end

    // Warp state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            act_mask <= '0;
            ovf_err  <= 1'b0;
        end else if (launch) begin
            pc       <= launch_pc;
            act_mask <= launch_mask;
            ovf_err  <= 1'b0;
        end else if (do_ovf) begin
            ovf_err  <= 1'b1;
        end else if (do_pop) begin
            pc       <= top_resume;
            act_mask <= top_mask;
        end else begin
            pc       <= pc_step;
            if (kind == BK_SPLIT)
                act_mask <= taken_grp;
        end
    end

    assert_adv_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !br && !launch && !do_pop) |=>
            (pc == $past(pc) + PC_W'(1)) && (act_mask == $past(act_mask)));
    assert_uniform_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br && kind != BK_SPLIT && !launch && !do_pop) |=> $stable(act_mask));
    assert_split_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> ((act_mask & ~$past(act_mask)) == '0) && (act_mask != '0)
                    && (act_mask != $past(act_mask)));
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !launch) |=> ovf_err);
    assert_ovf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        do_ovf |=> $stable(pc) && $stable(act_mask) && ovf_err);
    assert_launch_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !ovf_err);

endmodule

// File: tb/simt_warp_divergence_test.sv
`timescale 1ns/100ps
module simt_warp_divergence_test;

    localparam int LANES = 32;
    localparam int PC_W  = 16;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             launch;
    logic [PC_W-1:0]  launch_pc;
    logic [LANES-1:0] launch_mask;
    logic             adv;
    logic             br;
    logic [LANES-1:0] br_taken;
    logic [PC_W-1:0]  br_target;
    logic [PC_W-1:0]  br_reconv;
    logic [PC_W-1:0]  br_fallthru;
    logic [PC_W-1:0]  pc;
    logic [LANES-1:0] act_mask;
    logic             ovf_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Behavioural reference state.
    typedef struct {
        logic [PC_W-1:0]  join_pc;
        logic [PC_W-1:0]  resume_pc;
        logic [LANES-1:0] mask;
    } rec_t;
    rec_t             ref_q[$];
    logic [PC_W-1:0]  ref_pc;
    logic [LANES-1:0] ref_mask;
    bit               ref_err;

    always #2.5 clk = ~clk;

    simt_warp_divergence #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pc(launch_pc),
        .launch_mask(launch_mask), .adv(adv), .br(br), .br_taken(br_taken),
        .br_target(br_target), .br_reconv(br_reconv), .br_fallthru(br_fallthru),
        .pc(pc), .act_mask(act_mask), .ovf_err(ovf_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "pc", 64'(pc), 64'(ref_pc));
        chk(tag, "mask", 64'(act_mask), 64'(ref_mask));
        chk(tag, "ovf_err", 64'(ovf_err), 64'(ref_err));
    endtask

    // Reference: land on an address, taking a join record if it matches.
    task automatic ref_move(input logic [PC_W-1:0] nxt);
        if (ref_q.size() > 0 && nxt == ref_q[$].join_pc) begin
            ref_pc   = ref_q[$].resume_pc;
            ref_mask = ref_q[$].mask;
            void'(ref_q.pop_back());
        end else begin
            ref_pc = nxt;
        end
    endtask

    // Apply one cycle of stimulus (at a falling edge), update the reference, compare.
    task automatic cyc(input bit l, input logic [PC_W-1:0] lpc, input logic [LANES-1:0] lm,
                       input bit a, input bit b, input logic [LANES-1:0] tk,
                       input logic [PC_W-1:0] tg, input logic [PC_W-1:0] rc,
                       input logic [PC_W-1:0] ft, input string tag);
        logic [LANES-1:0] t;
        launch = l; launch_pc = lpc; launch_mask = lm; adv = a; br = b;
        br_taken = tk; br_target = tg; br_reconv = rc; br_fallthru = ft;
        if (l) begin
            ref_pc = lpc; ref_mask = lm; ref_err = 0; ref_q.delete();
        end else if (b) begin
            t = tk & ref_mask;
            if (t == ref_mask)      ref_move(tg);
            else if (t == '0)       ref_move(ft);
            else if (ref_q.size() + 2 > DEPTH) ref_err = 1;
            else begin
                ref_q.push_back('{join_pc: rc, resume_pc: rc, mask: ref_mask});
                ref_q.push_back('{join_pc: rc, resume_pc: ft, mask: ref_mask & ~tk});
                ref_pc = tg; ref_mask = t;
            end
        end else if (a) begin
            ref_move(ref_pc + PC_W'(1));
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic go(input logic [PC_W-1:0] p, input logic [LANES-1:0] m, input string tag);
        cyc(1, p, m, 0, 0, '0, '0, '0, '0, tag);
    endtask
    task automatic step(input string tag);
        cyc(0, '0, '0, 1, 0, '0, '0, '0, '0, tag);
    endtask
    task automatic branch(input logic [LANES-1:0] tk, input logic [PC_W-1:0] tg,
                          input logic [PC_W-1:0] rc, input logic [PC_W-1:0] ft,
                          input string tag);
        cyc(0, '0, '0, 0, 1, tk, tg, rc, ft, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #500us;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; launch = 0; launch_pc = '0; launch_mask = '0; adv = 0; br = 0;
        br_taken = '0; br_target = '0; br_reconv = '0; br_fallthru = '0;
        ref_pc = '0; ref_mask = '0; ref_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1;

        // R2, R3: launch, sequential steps, idle hold
        go(16'h0100, '1, "R2");
        step("R3"); step("R3");
        chk("R3", "pc", 64'(pc), 64'h0102);
        cyc(0, '0, '0, 0, 0, '0, '0, '0, '0, "R3");

        // R4: uniform taken; R5: outcome only outside the mask
        branch('1, 16'h0180, 16'h0190, 16'h0103, "R4");
        chk("R4", "pc", 64'(pc), 64'h0180);
        go(16'h0100, 32'h0000_FFFF, "R2");
        branch(32'hFFFF_00FF | 32'h00FF_FF00, 16'h0150, 16'h0160, 16'h0101, "R4");
        branch(32'hFFFF_0000, 16'h0170, 16'h0178, 16'h0102, "R5");
        chk("R5", "pc", 64'(pc), 64'h0102);
        chk("R5", "mask", 64'(act_mask), 64'h0000_FFFF);

        // R6, R7, R8: single divergence, even lanes taken
        go(16'h0200, '1, "R2");
        branch(32'h5555_5555, 16'h0210, 16'h0220, 16'h0218, "R6");
        chk("R6", "mask", 64'(act_mask), 64'h5555_5555);
        for (int i = 0; i < 8; i++) step("R7");
        for (int i = 0; i < 8; i++) step("R7");
        chk("R7", "pc", 64'(pc), 64'h0218);
        chk("R7", "mask", 64'(act_mask), 64'hAAAA_AAAA);
        for (int i = 0; i < 8; i++) step("R8");
        chk("R8", "pc", 64'(pc), 64'h0220);
        chk("R8", "mask", 64'(act_mask), 64'hFFFF_FFFF);

        // R9: nested divergence
        go(16'h0500, '1, "R2");
        branch(32'h0000_FFFF, 16'h0510, 16'h0540, 16'h0530, "R9");
        branch(32'h0000_00FF, 16'h0511, 16'h0514, 16'h0513, "R9");
        step("R9"); step("R9"); step("R9");
        chk("R9", "inner pc", 64'(pc), 64'h0513);
        chk("R9", "inner mask", 64'(act_mask), 64'h0000_FF00);
        step("R9");
        chk("R9", "inner join mask", 64'(act_mask), 64'h0000_FFFF);
        for (int i = 0; i < 44; i++) step("R9");
        chk("R9", "outer pc", 64'(pc), 64'h0530);
        chk("R9", "outer mask", 64'(act_mask), 64'hFFFF_0000);
        for (int i = 0; i < 16; i++) step("R9");
        chk("R9", "final mask", 64'(act_mask), 64'hFFFF_FFFF);

        // R10: overflow on the split past the store's capacity
        go(16'h0400, '1, "R2");
        for (int k = 0; k < DEPTH / 2; k++)
            branch(~((32'h2 << k) - 32'h1), PC_W'(16'h0410 + 16'h10 * k),
                   16'h04F0, 16'h0480, "R10");
        chk("R10", "no error yet", 64'(ovf_err), 64'h0);
        branch(32'hFFFF_FFC0, 16'h0470, 16'h04F0, 16'h0480, "R10");
        chk("R10", "err", 64'(ovf_err), 64'h1);
        chk("R10", "pc held", 64'(pc), 64'(16'h0410 + 16'h10 * (DEPTH / 2 - 1)));
        step("R10");
        chk("R10", "sticky", 64'(ovf_err), 64'h1);
        go(16'h0600, 32'h0F0F_0F0F, "R2");
        chk("R2", "err cleared", 64'(ovf_err), 64'h0);

        // Randomised phase against the reference, every cycle
        for (int n = 0; n < 4000; n++) begin
            int sel = $urandom_range(0, 99);
            logic [LANES-1:0] tk;
            int tsel = $urandom_range(0, 2);
            tk = (tsel == 0) ? '1 : (tsel == 1) ? '0 : LANES'($urandom);
            if (sel < 2)
                go(PC_W'(16'h0300 + $urandom_range(0, 15)), LANES'($urandom), "R9");
            else if (sel < 25)
                branch(tk, PC_W'(16'h0300 + $urandom_range(0, 31)),
                       PC_W'(16'h0300 + $urandom_range(0, 31)),
                       PC_W'(16'h0300 + $urandom_range(0, 31)), "R9");
            else if (sel < 90)
                step("R9");
            else
                cyc(0, '0, '0, 0, 0, '0, '0, '0, '0, "R3");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule